// File: doc/BRIEF.md
# Gate Driver Fault Supervisor

This block gathers the protection flags of a three-phase gate driver and decides whether the output stages may drive. Its inputs are asynchronous comparator levels:

- undervoltage on the power supply, the logic supply and the gate supply
- overvoltage on the gate supply
- an overtemperature warning
- an overtemperature shutdown
- an overcurrent warning

Every flag is resynchronized and glitch-filtered before it has any effect.

Each event has its own policy. Some faults are latched and some recover by themselves. Each event is routed in its own way to the active-low fault pin, to the active-low warning pin and to a sticky status word. When the logic supply recovers from an undervoltage, the whole status word is cleared.

Latched faults are released in one of two ways, and only while no shutdown flag is still active:

- a low-then-high transition on the enable pin
- a one-clock gate-reset command coming from the serial register interface

A 2-bit mode setting selects which warnings the warning pin shows. There is no streaming data path: every pin is a plain level or a strobe.

Top module: `gfs_supervisor`

## Requirements
- R1: A fault input takes effect only after it has held one level for 4 consecutive clocks once it has passed the 2-flop synchronizer. A pulse of 3 clocks is dropped and sets no status bit. A level change on the raw input reaches the filtered flag 6 clock edges later.
- R2: A filtered gate-supply overvoltage latches. While latched, it drops gate_en_o and cp_en_o and drives fault_n_o low. All three stay that way after the input clears, until a valid clear.
- R3: A filtered overtemperature shutdown latches. While latched, it drops gate_en_o and cp_en_o and drives fault_n_o low. After the input clears, only a clear event releases it.
- R4: Undervoltage on the power, logic or gate supply drops gate_en_o and drives fault_n_o low, and leaves cp_en_o high. Both outputs recover by themselves once the filtered flag clears.
- R5: When the filtered logic-supply undervoltage falls, status_o becomes all zero on the next edge. The logic-supply undervoltage has no status bit.
- R6: An overtemperature warning shuts nothing down: gate_en_o, cp_en_o and fault_n_o do not change. It sets status bit 3 and, in the default mode, drives warn_n_o low.
- R7: warn_sel_i controls what warn_n_o reports:

  | warn_sel_i | warn_n_o goes low on |
  |---|---|
  | 00 or 11 | either warning |
  | 01 | overtemperature warning only |
  | 10 | overcurrent warning only |

- R8: After reset, fault_n_o stays low until the internal gate enable (enable pin high and no shutdown cause) has gone high once.
- R9: The status bits are set by their filtered flags and are sticky:

  | Bit | Flag |
  |---|---|
  | 0 | power undervoltage |
  | 1 | gate-supply undervoltage |
  | 2 | gate-supply overvoltage |
  | 3 | overtemperature warning |
  | 4 | overtemperature shutdown |
  | 5 | overcurrent warning |

  A stat_rd_i strobe clears the status bits, except that bits 2 and 4 stay set while their latch is set.
- R10: A one-clock spi_gate_rst_i pulse releases the latched faults on the next edge, provided no shutdown flag is active.
- R11: A clear event (an enable pin rise that follows a fall, or a gate-reset pulse) has no effect while the filtered overvoltage or overtemperature-shutdown flag is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pvdd_uv_i | input | 1 | Power supply undervoltage flag (async) |
| dvdd_uv_i | input | 1 | Logic supply undervoltage flag (async) |
| gvdd_uv_i | input | 1 | Gate supply undervoltage flag (async) |
| gvdd_ov_i | input | 1 | Gate supply overvoltage flag (async) |
| ot_warn_i | input | 1 | Overtemperature warning flag (async) |
| ot_shut_i | input | 1 | Overtemperature shutdown flag (async) |
| oc_warn_i | input | 1 | Overcurrent warning flag (async) |
| en_pin_i | input | 1 | Gate enable pin (async) |
| spi_gate_rst_i | input | 1 | One-clock gate reset command, synchronous |
| warn_sel_i | input | 2 | Warning pin reporting mode |
| stat_rd_i | input | 1 | Status read strobe, synchronous |
| fault_n_o | output | 1 | Active-low fault indication |
| warn_n_o | output | 1 | Active-low warning indication |
| gate_en_o | output | 1 | 1 = gates may drive, 0 = high impedance with weak pulldown |
| cp_en_o | output | 1 | Charge pump enable |
| status_o | output | 6 | Sticky status word |

## Verification
Flag outputs are due at fixed delays after a raw input change. Undervoltage and warning effects appear at the pins after the sixth clock edge. Latched faults and status bits appear after the seventh edge. An enable-pin rise releases a latch at the third edge, and a gate-reset pulse releases it at the next edge. The filter case samples at the falling edge after edge five and again after edge six, so an error of one cycle either way is caught. The other checks sample only after a settling margin of several cycles that is longer than any of these delays.

// File: rtl/gfs_pkg.sv
package gfs_pkg;
  localparam int EV_PVDD_UV = 0;
  localparam int EV_DVDD_UV = 1;
  localparam int EV_GVDD_UV = 2;
  localparam int EV_GVDD_OV = 3;
  localparam int EV_OT_WARN = 4;
  localparam int EV_OT_SHUT = 5;
  localparam int EV_OC_WARN = 6;
  localparam int NUM_EV     = 7;

  localparam int ST_PVDD_UV = 0;
  localparam int ST_GVDD_UV = 1;
  localparam int ST_GVDD_OV = 2;
  localparam int ST_OT_WARN = 3;
  localparam int ST_OT_SHUT = 4;
  localparam int ST_OC_WARN = 5;
  localparam int ST_W       = 6;

  typedef enum logic [1:0] {
    WM_BOTH  = 2'b00,
    WM_OT    = 2'b01,
    WM_OC    = 2'b10,
    WM_BOTHX = 2'b11
  } warn_mode_e;
endpackage

// File: rtl/gfs_filter.sv
module gfs_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic filt_o
);
  localparam int CW = (FILT_LEN > 2) ? $clog2(FILT_LEN) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(FILT_LEN - 1);

  logic [SYNC_STAGES-1:0] sh_q;
  logic                   smp;
  logic [CW-1:0]          cnt_q;
  logic                   filt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[SYNC_STAGES-2:0], raw_i};
  end

  assign smp = sh_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      filt_q <= 1'b0;
    end else if (smp == filt_q) begin
      cnt_q <= '0;
    end else if (cnt_q == CNT_LAST) begin
      filt_q <= smp;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign filt_o = filt_q;

  AST_FILT_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(filt_q) |-> ($past(cnt_q) == CNT_LAST)); // R1
endmodule

// File: rtl/gfs_latch_ctl.sv
module gfs_latch_ctl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_pin_i,
  input  logic spi_rst_i,
  input  logic ov_f_i,
  input  logic ot_f_i,
  input  logic uv_any_i,
  output logic ov_lat_o,
  output logic ot_lat_o,
  output logic gate_en_o,
  output logic cp_en_o,
  output logic fault_n_o
);
  logic [SYNC_STAGES-1:0] en_sh_q;
  logic en_s, en_q, armed_q;
  logic rise, fall, rst_evt, clr_ok;
  logic ov_lat_q, ot_lat_q, started_q, gate_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_sh_q <= '0;
      en_q    <= 1'b0;
    end else begin
      en_sh_q <= {en_sh_q[SYNC_STAGES-2:0], en_pin_i};
      en_q    <= en_s;
    end
  end

  assign en_s    = en_sh_q[SYNC_STAGES-1];
  assign rise    = en_s & ~en_q;
  assign fall    = ~en_s & en_q;
  assign rst_evt = (rise & armed_q) | spi_rst_i;
  assign clr_ok  = rst_evt & ~ov_f_i & ~ot_f_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    armed_q <= 1'b0;
    else if (fall) armed_q <= 1'b1;
    else if (rise) armed_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_lat_q <= 1'b0;
      ot_lat_q <= 1'b0;
    end else begin
      if (ov_f_i)      ov_lat_q <= 1'b1;
      else if (clr_ok) ov_lat_q <= 1'b0;
      if (ot_f_i)      ot_lat_q <= 1'b1;
      else if (clr_ok) ot_lat_q <= 1'b0;
    end
  end

  assign gate_int = en_s & ~uv_any_i & ~ov_lat_q & ~ot_lat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        started_q <= 1'b0;
    else if (gate_int) started_q <= 1'b1;
  end

  assign ov_lat_o  = ov_lat_q;
  assign ot_lat_o  = ot_lat_q;
  assign gate_en_o = gate_int;
  assign cp_en_o   = ~ov_lat_q & ~ot_lat_q;
  assign fault_n_o = started_q & ~uv_any_i & ~ov_lat_q & ~ot_lat_q;

  AST_OV_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_lat_q && !spi_rst_i && !rise) |=> ov_lat_q); // R2
  AST_OT_CP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    ot_lat_q |-> (!cp_en_o && !fault_n_o && !gate_en_o)); // R3
  AST_OT_RELEASE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ot_lat_q) |-> $past(spi_rst_i || (en_s && !en_q))); // R10
  AST_CLR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ot_f_i || ov_f_i) |=> (ot_lat_q || ov_lat_q)); // R11
  AST_UV_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    uv_any_i |-> (!gate_en_o && !fault_n_o)); // R4
  AST_STARTUP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !started_q |-> !fault_n_o); // R8
endmodule

// File: rtl/gfs_status.sv
module gfs_status
  import gfs_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_i,
  input  logic            dvdd_f_i,
  input  logic [ST_W-1:0] set_i,
  input  logic [ST_W-1:0] hold_i,
  output logic [ST_W-1:0] status_o
);
  logic            dvdd_q;
  logic            wipe;
  logic [ST_W-1:0] st_q, st_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dvdd_q <= 1'b0;
    else        dvdd_q <= dvdd_f_i;
  end

  assign wipe = dvdd_q & ~dvdd_f_i;

  always_comb begin
    if (wipe) st_d = '0;
    else      st_d = (rd_i ? '0 : st_q) | set_i | hold_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign status_o = st_q;

  AST_WIPE_ON_RECOVER: assert property (@(posedge clk) disable iff (!rst_n)
    (dvdd_q && !dvdd_f_i) |=> (status_o == '0)); // R5
  AST_STICKY_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (!wipe && !rd_i) |=> ((status_o & $past(status_o)) == $past(status_o))); // R9
  AST_LATCH_HOLDS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!wipe && hold_i != '0) |=> ((status_o & $past(hold_i)) == $past(hold_i))); // R9
endmodule

// File: rtl/gfs_supervisor.sv
module gfs_supervisor
  import gfs_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pvdd_uv_i,
  input  logic            dvdd_uv_i,
  input  logic            gvdd_uv_i,
  input  logic            gvdd_ov_i,
  input  logic            ot_warn_i,
  input  logic            ot_shut_i,
  input  logic            oc_warn_i,
  input  logic            en_pin_i,
  input  logic            spi_gate_rst_i,
  input  logic [1:0]      warn_sel_i,
  input  logic            stat_rd_i,
  output logic            fault_n_o,
  output logic            warn_n_o,
  output logic            gate_en_o,
  output logic            cp_en_o,
  output logic [ST_W-1:0] status_o
);
  logic [NUM_EV-1:0] raw, flt;
  logic              uv_any, ov_lat, ot_lat;
  logic              show_ot, show_oc;
  logic [ST_W-1:0]   st_set, st_hold;
  warn_mode_e        mode;

  always_comb begin
    raw             = '0;
    raw[EV_PVDD_UV] = pvdd_uv_i;
    raw[EV_DVDD_UV] = dvdd_uv_i;
    raw[EV_GVDD_UV] = gvdd_uv_i;
    raw[EV_GVDD_OV] = gvdd_ov_i;
    raw[EV_OT_WARN] = ot_warn_i;
    raw[EV_OT_SHUT] = ot_shut_i;
    raw[EV_OC_WARN] = oc_warn_i;
  end

  for (genvar g = 0; g < NUM_EV; g++) begin : g_flt
    gfs_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_flt (
      .clk   (clk),
      .rst_n (rst_n),
      .raw_i (raw[g]),
      .filt_o(flt[g])
    );
  end

  assign uv_any = flt[EV_PVDD_UV] | flt[EV_DVDD_UV] | flt[EV_GVDD_UV];

  gfs_latch_ctl #(.SYNC_STAGES(SYNC_STAGES)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_pin_i (en_pin_i),
    .spi_rst_i(spi_gate_rst_i),
    .ov_f_i   (flt[EV_GVDD_OV]),
    .ot_f_i   (flt[EV_OT_SHUT]),
    .uv_any_i (uv_any),
    .ov_lat_o (ov_lat),
    .ot_lat_o (ot_lat),
    .gate_en_o(gate_en_o),
    .cp_en_o  (cp_en_o),
    .fault_n_o(fault_n_o)
  );

  always_comb begin
    st_set             = '0;
    st_set[ST_PVDD_UV] = flt[EV_PVDD_UV];
    st_set[ST_GVDD_UV] = flt[EV_GVDD_UV];
    st_set[ST_GVDD_OV] = flt[EV_GVDD_OV];
    st_set[ST_OT_WARN] = flt[EV_OT_WARN];
    st_set[ST_OT_SHUT] = flt[EV_OT_SHUT];
    st_set[ST_OC_WARN] = flt[EV_OC_WARN];
    st_hold             = '0;
    st_hold[ST_GVDD_OV] = ov_lat;
    st_hold[ST_OT_SHUT] = ot_lat;
  end

  gfs_status u_st (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_i    (stat_rd_i),
    .dvdd_f_i(flt[EV_DVDD_UV]),
    .set_i   (st_set),
    .hold_i  (st_hold),
    .status_o(status_o)
  );

  assign mode     = warn_mode_e'(warn_sel_i);
  assign show_ot  = (mode != WM_OC);
  assign show_oc  = (mode != WM_OT);
  assign warn_n_o = ~((show_ot & flt[EV_OT_WARN]) | (show_oc & flt[EV_OC_WARN]));

  AST_WARN_OT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == WM_OT && !flt[EV_OT_WARN]) |-> warn_n_o); // R7
  AST_WARN_NO_SHUTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (flt[EV_OT_WARN] && !uv_any && !ov_lat && !ot_lat) |-> cp_en_o); // R6
endmodule

// File: tb/sim_gfs_supervisor.sv
module sim_gfs_supervisor;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pvdd_uv = 0, dvdd_uv = 0, gvdd_uv = 0, gvdd_ov = 0;
  logic ot_warn = 0, ot_shut = 0, oc_warn = 0, en_pin = 0, spi_rst = 0, stat_rd = 0;
  logic [1:0] warn_sel = 2'b00;
  logic fault_n, warn_n, gate_en, cp_en;
  logic [5:0] status;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  gfs_supervisor u0 (
    .clk(clk), .rst_n(rst_n),
    .pvdd_uv_i(pvdd_uv), .dvdd_uv_i(dvdd_uv), .gvdd_uv_i(gvdd_uv), .gvdd_ov_i(gvdd_ov),
    .ot_warn_i(ot_warn), .ot_shut_i(ot_shut), .oc_warn_i(oc_warn),
    .en_pin_i(en_pin), .spi_gate_rst_i(spi_rst), .warn_sel_i(warn_sel), .stat_rd_i(stat_rd),
    .fault_n_o(fault_n), .warn_n_o(warn_n), .gate_en_o(gate_en), .cp_en_o(cp_en),
    .status_o(status)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_status();
    stat_rd = 1'b1;
    cyc(1);
    stat_rd = 1'b0;
    cyc(1);
  endtask

  task automatic t_startup();
    chk("R8 fault low after reset", fault_n, 0);
    chk("R8 status zero after reset", status, 0);
    en_pin = 1'b1;
    cyc(5);
    chk("R8 gate enabled", gate_en, 1);
    chk("R8 fault released", fault_n, 1);
    chk("R8 warn idle", warn_n, 1);
  endtask

  task automatic t_filter();
    int lowseen = 0;
    pvdd_uv = 1'b1;
    cyc(5);
    chk("R1 no effect after 5 edges", fault_n, 1);
    cyc(1);
    chk("R1 effect after 6 edges", fault_n, 0);
    pvdd_uv = 1'b0;
    cyc(10);
    rd_status();
    pvdd_uv = 1'b1;
    cyc(3);
    pvdd_uv = 1'b0;
    for (int i = 0; i < 10; i++) begin
      cyc(1);
      if (!fault_n) lowseen = 1;
    end
    chk("R1 3-cycle glitch dropped", lowseen, 0);
    chk("R1 glitch leaves status", status, 0);
    pvdd_uv = 1'b1;
    cyc(4);
    pvdd_uv = 1'b0;
    cyc(10);
    chk("R1 4-cycle pulse taken", status, 6'b000001);
    rd_status();
  endtask

  task automatic t_uv();
    gvdd_uv = 1'b1;
    cyc(8);
    chk("R4 gate hiz", gate_en, 0);
    chk("R4 fault low", fault_n, 0);
    chk("R4 pump stays on", cp_en, 1);
    gvdd_uv = 1'b0;
    cyc(8);
    chk("R4 gate recovers", gate_en, 1);
    chk("R4 fault recovers", fault_n, 1);
    chk("R9 uv bit sticky", status, 6'b000010);
    rd_status();
    chk("R9 read clears", status, 0);
  endtask

  task automatic t_otw();
    warn_sel = 2'b00;
    ot_warn = 1'b1;
    cyc(8);
    chk("R6 warn pin low", warn_n, 0);
    chk("R6 gate on", gate_en, 1);
    chk("R6 fault idle", fault_n, 1);
    chk("R6 pump on", cp_en, 1);
    chk("R6 status bit3", status, 6'b001000);
    ot_warn = 1'b0;
    cyc(8);
    chk("R6 warn released", warn_n, 1);
    rd_status();
  endtask

  task automatic t_mode();
    oc_warn = 1'b1;
    warn_sel = 2'b01;
    cyc(8);
    chk("R7 OT-only hides OC", warn_n, 1);
    warn_sel = 2'b10;
    cyc(1);
    chk("R7 OC-only shows OC", warn_n, 0);
    warn_sel = 2'b00;
    cyc(1);
    chk("R7 default shows OC", warn_n, 0);
    oc_warn = 1'b0;
    ot_warn = 1'b1;
    warn_sel = 2'b10;
    cyc(8);
    chk("R7 OC-only hides OT", warn_n, 1);
    warn_sel = 2'b01;
    cyc(1);
    chk("R7 OT-only shows OT", warn_n, 0);
    ot_warn = 1'b0;
    warn_sel = 2'b00;
    cyc(8);
    rd_status();
    chk("R9 status cleared", status, 0);
  endtask

  task automatic t_ov();
    gvdd_ov = 1'b1;
    cyc(10);
    gvdd_ov = 1'b0;
    cyc(10);
    chk("R2 gate off latched", gate_en, 0);
    chk("R2 pump off latched", cp_en, 0);
    chk("R2 fault latched", fault_n, 0);
    rd_status();
    chk("R9 ov bit held by latch", status, 6'b000100);
    en_pin = 1'b0;
    cyc(5);
    en_pin = 1'b1;
    cyc(6);
    chk("R2 pin reset gate", gate_en, 1);
    chk("R2 pin reset pump", cp_en, 1);
    chk("R2 pin reset fault", fault_n, 1);
    rd_status();
    chk("R9 ov bit cleared", status, 0);
  endtask

  task automatic t_ot();
    ot_shut = 1'b1;
    cyc(10);
    chk("R3 fault low", fault_n, 0);
    chk("R3 pump off", cp_en, 0);
    chk("R3 gate off", gate_en, 0);
    rd_status();
    chk("R9 ot bit held", status, 6'b010000);
    en_pin = 1'b0;
    cyc(5);
    en_pin = 1'b1;
    cyc(6);
    chk("R11 pin clear refused", fault_n, 0);
    spi_rst = 1'b1;
    cyc(1);
    spi_rst = 1'b0;
    cyc(2);
    chk("R11 spi clear refused", gate_en, 0);
    ot_shut = 1'b0;
    cyc(10);
    chk("R3 still latched", fault_n, 0);
    spi_rst = 1'b1;
    cyc(1);
    spi_rst = 1'b0;
    cyc(2);
    chk("R10 spi reset gate", gate_en, 1);
    chk("R10 spi reset fault", fault_n, 1);
    chk("R10 spi reset pump", cp_en, 1);
    rd_status();
    chk("R9 ot bit cleared", status, 0);
  endtask

  task automatic t_dvdd();
    ot_warn = 1'b1;
    cyc(8);
    ot_warn = 1'b0;
    cyc(8);
    dvdd_uv = 1'b1;
    cyc(10);
    chk("R4 logic uv fault", fault_n, 0);
    chk("R4 logic uv gate", gate_en, 0);
    chk("R5 no logic uv bit", status, 6'b001000);
    dvdd_uv = 1'b0;
    cyc(10);
    chk("R5 status wiped", status, 0);
    chk("R5 fault recovers", fault_n, 1);
  endtask

  initial begin
    #1_000_000;
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    t_startup();
    t_filter();
    t_uv();
    t_otw();
    t_mode();
    t_ov();
    t_ot();
    t_dvdd();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule